// File: doc/BRIEF.md
# Multicycle Accumulator Sequencer

This block is the control and register core of a small accumulator machine. It runs every instruction as a fixed series of single-register moves over one synchronous memory port. Each fetch copies the program counter into the address register and raises a read strobe. It captures the returned word in the data register, moves that word into the instruction register and then decodes it. Operands come over the same port through the same two staging registers. Stores do the same in the other direction: the accumulator goes to the data register first, and the write strobe follows.

The instruction word is one 16-bit memory word. The instruction set has load, add and store against memory, an add with a zero-extended immediate, and three branches: one always taken, one taken on zero and one taken on negative. A halt instruction stops the machine and raises a status output, which stays high until reset. The block sits next to a single-port synchronous RAM. The RAM must return read data on the clock edge after the read strobe and must write on the edge where the write strobe is high.

Top module: `acc_seq_top`

## Requirements
- R1: While reset is high, `halted`, `mem_rd` and `mem_wr` are low. Reset clears the program counter, the accumulator and both flags, and it puts the controller in the fetch phase. On the first clock edge after reset falls, `mem_rd` goes high with `mem_addr` = 0.
- R2: A fetch takes four steps: the PC goes to the address register, a read is strobed, the returned word goes to the data register, and the data register goes to the instruction register. The PC advances by one during the fetch, so instructions without a taken branch run from consecutive addresses.
- R3: An instruction word holds the opcode in bits 15:12 and the address or immediate in bits 11:0. The opcodes are 0 halt, 1 load, 2 store, 3 add, 4 add-immediate, 5 branch, 6 branch-if-zero and 7 branch-if-negative. Opcodes 8 to 15 change no register, flag or memory word and take 5 cycles.
- R4: A load sets ACC to M[a]. It sets Z when the result is zero and N to bit 15 of the result.
- R5: An add sets ACC to (ACC + M[a]) mod 2^16 and updates Z and N from the result.
- R6: A store gives one write strobe with `mem_addr` = a and `mem_wdata` = ACC. It changes neither ACC nor the flags.
- R7: An add-immediate adds bits 11:0 of the instruction to ACC, zero-extended to 16 bits, and updates Z and N.
- R8: A branch always loads the PC with bits 11:0 of the instruction.
- R9: Branch-if-zero loads the PC only when Z is 1, and branch-if-negative only when N is 1. Only load, add and add-immediate change Z and N.
- R10: After a halt is decoded, `halted` goes high and stays high until reset. While it is high, no read or write strobe is issued.
- R11: Read data is taken from `mem_rdata` one cycle after the read strobe, and `mem_rd` and `mem_wr` are never high together. Instructions that do not touch memory take 5 cycles, including the branches, add-immediate and halt up to `halted`. A store takes 7 cycles, and a load or an add takes 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory word address, driven from the address register |
| mem_rd | output | 1 | Read strobe, data expected on the next edge |
| mem_wr | output | 1 | Write strobe, committed on the same edge |
| mem_wdata | output | 16 | Write data, driven from the data register |
| mem_rdata | input | 16 | Read data from memory |
| halted | output | 1 | High once a halt has been executed |

## Verification
The assertions assume the memory keeps the contract above. A read strobe must be answered with a word on the following edge, and a word may only change in memory when the block drives the write strobe. The bench memory is a plain registered array that honours exactly this contract, and program images are loaded into it only while reset is high. Programs use only words 0 to 255, so the bench array decodes just the low address bits. Every program ends in a halt, so the halted-state properties are reached on every run.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_HALT  = 4'd0;
  localparam logic [OPC_W-1:0] OP_LOAD  = 4'd1;
  localparam logic [OPC_W-1:0] OP_STORE = 4'd2;
  localparam logic [OPC_W-1:0] OP_ADD   = 4'd3;
  localparam logic [OPC_W-1:0] OP_ADDI  = 4'd4;
  localparam logic [OPC_W-1:0] OP_BR    = 4'd5;
  localparam logic [OPC_W-1:0] OP_BRZ   = 4'd6;
  localparam logic [OPC_W-1:0] OP_BRN   = 4'd7;

  typedef enum logic [3:0] {
    ST_FADDR,
    ST_FREAD,
    ST_FCAP,
    ST_FIR,
    ST_DEC,
    ST_OREAD,
    ST_OCAP,
    ST_EXEC,
    ST_SMDR,
    ST_SWR,
    ST_HALT
  } seq_state_t;

  typedef enum logic [1:0] {
    ACC_HOLD,
    ACC_LOAD,
    ACC_ADD,
    ACC_ADDI
  } acc_op_t;

  typedef struct packed {
    logic    mar_pc;
    logic    mar_ir;
    logic    mdr_mem;
    logic    mdr_acc;
    logic    ir_ld;
    logic    pc_inc;
    logic    pc_ld;
    acc_op_t acc_op;
  } seq_ctl_t;

endpackage

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             flag_z,
  input  logic             flag_n,
  output seq_ctl_t         ctl,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             halted
);

  seq_state_t state, state_n;
  logic       rd_q, wr_q, halt_q;

  always_comb begin
    ctl     = '0;
    state_n = state;
    case (state)
      ST_FADDR: begin
        ctl.mar_pc = 1'b1;
        state_n    = ST_FREAD;
      end
      ST_FREAD: state_n = ST_FCAP;
      ST_FCAP: begin
        ctl.mdr_mem = 1'b1;
        ctl.pc_inc  = 1'b1;
        state_n     = ST_FIR;
      end
      ST_FIR: begin
        ctl.ir_ld = 1'b1;
        state_n   = ST_DEC;
      end
      ST_DEC: begin
        state_n = ST_FADDR;
        case (opcode)
          OP_HALT: state_n = ST_HALT;
          OP_LOAD, OP_ADD: begin
            ctl.mar_ir = 1'b1;
            state_n    = ST_OREAD;
          end
          OP_STORE: begin
            ctl.mar_ir = 1'b1;
            state_n    = ST_SMDR;
          end
          OP_ADDI: ctl.acc_op = ACC_ADDI;
          OP_BR:   ctl.pc_ld  = 1'b1;
          OP_BRZ:  ctl.pc_ld  = flag_z;
          OP_BRN:  ctl.pc_ld  = flag_n;
          default: state_n = ST_FADDR;
        endcase
      end
      ST_OREAD: state_n = ST_OCAP;
      ST_OCAP: begin
        ctl.mdr_mem = 1'b1;
        state_n     = ST_EXEC;
      end
      ST_EXEC: begin
        ctl.acc_op = (opcode == OP_LOAD) ? ACC_LOAD : ACC_ADD;
        state_n    = ST_FADDR;
      end
      ST_SMDR: begin
        ctl.mdr_acc = 1'b1;
        state_n     = ST_SWR;
      end
      ST_SWR:  state_n = ST_FADDR;
      ST_HALT: state_n = ST_HALT;
      default: state_n = ST_FADDR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FADDR;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      state  <= state_n;
      rd_q   <= (state_n == ST_FREAD) || (state_n == ST_OREAD);
      wr_q   <= (state_n == ST_SWR);
      halt_q <= (state_n == ST_HALT);
    end
  end

  assign mem_rd = rd_q;
  assign mem_wr = wr_q;
  assign halted = halt_q;

  assert_rw_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_capture_after_rd_R11: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_FCAP) || (state == ST_OCAP)) |-> $past(mem_rd));

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halted |-> (!mem_rd && !mem_wr));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted);

  assert_dec_after_ir_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DEC) |-> ($past(state) == ST_FIR));

endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath
  import acc_seq_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  seq_ctl_t         ctl,
  input  logic [DW-1:0]    mem_rdata,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  output logic [OPC_W-1:0] opcode,
  output logic             flag_z,
  output logic             flag_n,
  output logic [DW-1:0]    acc_o
);

  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr, ir, acc, alu_res;
  logic          z_q, n_q;
  logic [AW-1:0] ir_field;

  assign ir_field = ir[AW-1:0];

  always_comb begin
    case (ctl.acc_op)
      ACC_LOAD: alu_res = mdr;
      ACC_ADD:  alu_res = acc + mdr;
      ACC_ADDI: alu_res = acc + DW'(ir_field);
      default:  alu_res = acc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc  <= '0;
      mar <= '0;
      mdr <= '0;
      ir  <= '0;
      acc <= '0;
      z_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      if (ctl.mar_pc)      mar <= pc;
      else if (ctl.mar_ir) mar <= ir_field;

      if (ctl.mdr_mem)      mdr <= mem_rdata;
      else if (ctl.mdr_acc) mdr <= acc;

      if (ctl.ir_ld) ir <= mdr;

      if (ctl.pc_ld)       pc <= ir_field;
      else if (ctl.pc_inc) pc <= pc + AW'(1);

      if (ctl.acc_op != ACC_HOLD) begin
        acc <= alu_res;
        z_q <= (alu_res == '0);
        n_q <= alu_res[DW-1];
      end
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mdr;
  assign opcode    = ir[DW-1 -: OPC_W];
  assign flag_z    = z_q;
  assign flag_n    = n_q;
  assign acc_o     = acc;

  assert_flags_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ctl.acc_op == ACC_HOLD) |=> $stable({z_q, n_q}));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    ctl.pc_inc |=> (pc == $past(pc) + AW'(1)));

  assert_z_matches_acc_R4: assert property (@(posedge clk) disable iff (rst)
    (ctl.acc_op != ACC_HOLD) |=> (z_q == (acc == '0)));

endmodule

// File: rtl/acc_seq_top.sv
module acc_seq_top
  import acc_seq_pkg::*;
#(
  parameter  int DATA_W = 16,
  localparam int ADDR_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              halted
);

  seq_ctl_t         ctl;
  logic [OPC_W-1:0] opcode;
  logic             flag_z, flag_n;
  logic [DATA_W-1:0] acc;

  acc_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .flag_z (flag_z),
    .flag_n (flag_n),
    .ctl    (ctl),
    .mem_rd (mem_rd),
    .mem_wr (mem_wr),
    .halted (halted)
  );

  acc_seq_dpath #(
    .DW (DATA_W),
    .AW (ADDR_W)
  ) u_dpath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .opcode    (opcode),
    .flag_z    (flag_z),
    .flag_n    (flag_n),
    .acc_o     (acc)
  );

  assert_store_data_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (mem_wdata == acc));

endmodule

// File: tb/test_acc_seq_top.sv
`timescale 1ns/1ps
module test_acc_seq_top;

  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, halted;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  logic [DW-1:0] mem [256];

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic [AW-1:0] exp_a[$];
  logic [DW-1:0] exp_d[$];
  string         exp_t[$];

  always #2.5 clk = ~clk;

  acc_seq_top i_acc_seq_top (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .halted    (halted)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
  end

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic push_wr(input int a, input int d, input string tag);
    exp_a.push_back(AW'(a));
    exp_d.push_back(DW'(d));
    exp_t.push_back(tag);
  endtask

  // monitor: every write strobe is popped against the scoreboard
  always @(negedge clk) begin
    if (!rst && mem_wr) begin
      if (exp_a.size() == 0) begin
        chk(1'b0, "R6", "unexpected write address", int'(mem_addr), 0);
      end else begin
        automatic logic [AW-1:0] ea = exp_a.pop_front();
        automatic logic [DW-1:0] ed = exp_d.pop_front();
        automatic string         et = exp_t.pop_front();
        chk(mem_addr == ea, et, "write address", int'(mem_addr), int'(ea));
        chk(mem_wdata == ed, et, "write data", int'(mem_wdata), int'(ed));
      end
    end
  end

  function automatic logic [DW-1:0] enc(input int op, input int a);
    return {op[3:0], a[11:0]};
  endfunction

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'hDEAD;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(halted == 1'b0, "R1", "halted in reset", int'(halted), 0);
    chk(mem_rd == 1'b0, "R1", "rd in reset", int'(mem_rd), 0);
    chk(mem_wr == 1'b0, "R1", "wr in reset", int'(mem_wr), 0);
  endtask

  task automatic leave_reset();
    rst = 1'b0;
    @(negedge clk);
    chk(mem_rd == 1'b1, "R1", "first fetch strobe", int'(mem_rd), 1);
    chk(mem_addr == '0, "R1", "first fetch address", int'(mem_addr), 0);
  endtask

  task automatic run_to_halt(input int exp_cyc, input string tag);
    int guard = 0;
    while (!halted && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    chk(halted == 1'b1, "R10", "halted raised", int'(halted), 1);
    chk(cyc == exp_cyc, tag, "cycles to halt", cyc, exp_cyc);
    chk(exp_a.size() == 0, "R6", "writes outstanding", exp_a.size(), 0);
  endtask

  task automatic check_quiet();
    int strobes = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_rd || mem_wr || !halted) strobes++;
    end
    chk(strobes == 0, "R10", "activity after halt", strobes, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected halt");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // program A: memory ops, immediate, branches, unassigned opcode
    enter_reset();
    clear_mem();
    mem[100] = 16'h0005;
    mem[101] = 16'h0003;
    mem[102] = 16'h0000;
    mem[103] = 16'h8001;
    mem[0]  = enc(1, 100);
    mem[1]  = enc(3, 101);
    mem[2]  = enc(2, 200);
    mem[3]  = enc(4, 12'hFF0);
    mem[4]  = enc(2, 201);
    mem[5]  = enc(5, 8);
    mem[6]  = enc(2, 202);
    mem[7]  = enc(0, 0);
    mem[8]  = enc(1, 102);
    mem[9]  = enc(7, 12);
    mem[10] = enc(6, 13);
    mem[11] = enc(2, 203);
    mem[12] = enc(2, 204);
    mem[13] = enc(1, 103);
    mem[14] = enc(6, 30);
    mem[15] = enc(2, 205);
    mem[16] = enc(7, 18);
    mem[17] = enc(2, 206);
    mem[18] = 16'hF123;
    mem[19] = enc(3, 103);
    mem[20] = enc(2, 207);
    mem[21] = enc(6, 30);
    mem[22] = enc(7, 30);
    mem[23] = enc(4, 12'hFFE);
    mem[24] = enc(2, 208);
    mem[25] = enc(0, 0);
    mem[26] = enc(2, 209);
    mem[30] = enc(2, 210);
    push_wr(200, 16'h0008, "R5");
    push_wr(201, 16'h0FF8, "R7");
    push_wr(205, 16'h8001, "R4");
    push_wr(207, 16'h0002, "R3");
    push_wr(208, 16'h1000, "R7");
    leave_reset();
    run_to_halt(130, "R11");
    check_quiet();
    chk(mem[200] == 16'h0008, "R6", "stored word 200", int'(mem[200]), 16'h0008);
    chk(mem[202] == 16'hDEAD, "R8", "skipped store 202", int'(mem[202]), 16'hDEAD);
    chk(mem[203] == 16'hDEAD, "R9", "skipped store 203", int'(mem[203]), 16'hDEAD);
    chk(mem[204] == 16'hDEAD, "R9", "skipped store 204", int'(mem[204]), 16'hDEAD);
    chk(mem[206] == 16'hDEAD, "R9", "skipped store 206", int'(mem[206]), 16'hDEAD);
    chk(mem[209] == 16'hDEAD, "R10", "store after halt", int'(mem[209]), 16'hDEAD);
    chk(mem[210] == 16'hDEAD, "R9", "untaken target", int'(mem[210]), 16'hDEAD);
    chk(mem[100] == 16'h0005, "R2", "operand intact", int'(mem[100]), 16'h0005);

    // program B: leave Z set at halt
    enter_reset();
    clear_mem();
    mem[102] = 16'h0000;
    mem[0] = enc(1, 102);
    mem[1] = enc(0, 0);
    leave_reset();
    run_to_halt(13, "R11");

    // program C: reset from halt clears PC, ACC and Z
    enter_reset();
    clear_mem();
    mem[0] = enc(6, 3);
    mem[1] = enc(4, 7);
    mem[2] = enc(2, 220);
    mem[3] = enc(0, 0);
    push_wr(220, 16'h0007, "R1");
    leave_reset();
    run_to_halt(22, "R11");
    chk(mem[220] == 16'h0007, "R1", "stored after reset", int'(mem[220]), 16'h0007);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule